// File: doc/BRIEF.md
# Trace Start/Stop Gate

This block holds one sticky flag that says whether instruction trace is currently inside a start/stop window. Address comparators elsewhere in the trace unit produce one match pulse per comparator per cycle. A 32-bit control word chooses which comparators open the window and which ones close it. The flag is registered and feeds the instruction trace filter downstream.

Software writes the control word while the trace unit is disabled, then raises the enable. While the enable is high, writes to the control word are dropped, so the masks stay fixed for the whole trace session. When the enable drops, the flag falls to inactive. The number of comparators that are really implemented is a parameter. Mask bits above that count cannot be stored and always read back as zero.

Top module: `trace_gate_ctl`

## Requirements
- R1: The start mask sits in control word bits [7:0], with bit i selecting comparator i. While enabled, a cycle in which a start-selected comparator matches and no stop-selected comparator matches makes `ss_active` 1 after the next clock edge.
- R2: The stop mask sits in control word bits [23:16], with bit i selecting comparator i. While enabled, a cycle in which a stop-selected comparator matches makes `ss_active` 0 after the next clock edge.
- R3: When start-selected and stop-selected matches arrive in the same cycle, the stop takes priority and `ss_active` is 0 after the next edge.
- R4: Control word bits [31:24] and [15:8] drop written data and always read as zero.
- R5: Mask bits for comparator indices at or above NUM_CMP cannot be stored and always read as zero.
- R6: A write to the control word while `trace_en` is 1 is dropped. Both the readback value and the start/stop behaviour stay unchanged.
- R7: The control word lives at register offset 0x088. A write to any other offset is dropped. A read of any other offset returns zero. `reg_rdata` shows the addressed word one clock after `reg_addr` is presented.
- R8: After synchronous reset, `ss_active` is 0 and the control word reads as zero.
- R9: While `trace_en` is 0, `ss_active` is 0 after the next edge, whatever the comparator matches are.
- R10: While enabled, a cycle with no selected match leaves `ss_active` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trace_en | input | 1 | Trace unit enable; high blocks configuration writes |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the addressed offset |
| cmp_hit | input | NUM_CMP | Per-cycle match pulses, one per address comparator |
| ss_active | output | 1 | Registered start/stop window flag |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a start-selected match and a stop-selected match. The second pair is a configuration write and an asserted trace enable. The first pair is provoked by sweeping every combination of start mask, stop mask and match vector for a four-comparator build. Each result is judged against a bench model in which stop wins over start, and start wins over hold. The second pair is provoked by writing a conflicting mask while enabled. It is judged both by the readback and by the fact that a match on the would-be start comparator leaves the flag low.

// File: rtl/tss_pkg.sv
package tss_pkg;
  localparam int WORD_W    = 32;
  localparam int FIELD_W   = 8;
  localparam int START_LSB = 0;
  localparam int STOP_LSB  = 16;
endpackage

// File: rtl/tss_cfg_reg.sv
module tss_cfg_reg
  import tss_pkg::*;
#(
  parameter int NUM_CMP = 4,
  parameter int ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] OFFSET = 12'h088
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trace_en,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [WORD_W-1:0]  reg_wdata,
  output logic [NUM_CMP-1:0] start_mask,
  output logic [NUM_CMP-1:0] stop_mask,
  output logic [WORD_W-1:0]  reg_rdata
);
  logic              addr_hit;
  logic              wr_ok;
  logic [WORD_W-1:0] word_view;
  logic              unused_wdata;

  assign addr_hit     = (reg_addr == OFFSET);
  assign wr_ok        = reg_wr && addr_hit && !trace_en;
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_mask <= '0;
      stop_mask  <= '0;
    end else if (wr_ok) begin
      start_mask <= reg_wdata[START_LSB +: NUM_CMP];
      stop_mask  <= reg_wdata[STOP_LSB  +: NUM_CMP];
    end
  end

  always_comb begin
    word_view = '0;
    word_view[START_LSB +: NUM_CMP] = start_mask;
    word_view[STOP_LSB  +: NUM_CMP] = stop_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= addr_hit ? word_view : '0;
  end
endmodule

// File: rtl/tss_match_reduce.sv
module tss_match_reduce #(
  parameter int NUM_CMP = 4
) (
  input  logic [NUM_CMP-1:0] cmp_hit,
  input  logic [NUM_CMP-1:0] start_mask,
  input  logic [NUM_CMP-1:0] stop_mask,
  output logic               start_hit,
  output logic               stop_hit
);
  logic [NUM_CMP-1:0] start_sel;
  logic [NUM_CMP-1:0] stop_sel;

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    assign start_sel[i] = cmp_hit[i] & start_mask[i];
    assign stop_sel[i]  = cmp_hit[i] & stop_mask[i];
  end

  assign start_hit = |start_sel;
  assign stop_hit  = |stop_sel;
endmodule

// File: rtl/tss_flag.sv
module tss_flag (
  input  logic clk,
  input  logic rst,
  input  logic trace_en,
  input  logic start_hit,
  input  logic stop_hit,
  output logic active
);
  always_ff @(posedge clk) begin
    if (rst)            active <= 1'b0;
    else if (!trace_en) active <= 1'b0;
    else if (stop_hit)  active <= 1'b0;
    else if (start_hit) active <= 1'b1;
  end
endmodule

// File: rtl/trace_gate_ctl.sv
module trace_gate_ctl
  import tss_pkg::*;
#(
  parameter int NUM_CMP = 4,
  parameter int ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] OFFSET = 12'h088
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trace_en,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_CMP-1:0] cmp_hit,
  output logic               ss_active
);
  logic [NUM_CMP-1:0] start_mask;
  logic [NUM_CMP-1:0] stop_mask;
  logic               start_hit;
  logic               stop_hit;

  tss_cfg_reg #(.NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W), .OFFSET(OFFSET)) u_cfg (
    .clk(clk), .rst(rst), .trace_en(trace_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .start_mask(start_mask), .stop_mask(stop_mask), .reg_rdata(reg_rdata)
  );

  tss_match_reduce #(.NUM_CMP(NUM_CMP)) u_red (
    .cmp_hit(cmp_hit), .start_mask(start_mask), .stop_mask(stop_mask),
    .start_hit(start_hit), .stop_hit(stop_hit)
  );

  tss_flag u_flag (
    .clk(clk), .rst(rst), .trace_en(trace_en),
    .start_hit(start_hit), .stop_hit(stop_hit), .active(ss_active)
  );
endmodule

// File: rtl/tss_checker.sv
module tss_checker #(
  parameter int NUM_CMP = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               trace_en,
  input logic [NUM_CMP-1:0] cmp_hit,
  input logic [NUM_CMP-1:0] start_mask,
  input logic [NUM_CMP-1:0] stop_mask,
  input logic [31:0]        reg_rdata,
  input logic               ss_active
);
  logic any_start;
  logic any_stop;
  assign any_start = |(cmp_hit & start_mask);
  assign any_stop  = |(cmp_hit & stop_mask);

  a_r1_start_sets: assert property (@(posedge clk) disable iff (rst)
    (trace_en && any_start && !any_stop) |=> ss_active);

  a_r3_stop_wins: assert property (@(posedge clk) disable iff (rst)
    (trace_en && any_stop) |=> !ss_active);

  a_r9_disable_clears: assert property (@(posedge clk) disable iff (rst)
    !trace_en |=> !ss_active);

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (trace_en && !any_start && !any_stop) |=> $stable(ss_active));

  a_r6_locked_cfg: assert property (@(posedge clk) disable iff (rst)
    trace_en |=> ($stable(start_mask) && $stable(stop_mask)));

  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[31:24] == 8'h00) && (reg_rdata[15:8] == 8'h00));

  a_r5_unimpl_zero: assert property (@(posedge clk) disable iff (rst)
    ((reg_rdata[7:0] >> NUM_CMP) == 8'h00) && ((reg_rdata[23:16] >> NUM_CMP) == 8'h00));
endmodule

bind trace_gate_ctl tss_checker #(.NUM_CMP(NUM_CMP)) u_chk (
  .clk(clk), .rst(rst), .trace_en(trace_en), .cmp_hit(cmp_hit),
  .start_mask(start_mask), .stop_mask(stop_mask),
  .reg_rdata(reg_rdata), .ss_active(ss_active)
);

// File: tb/trace_gate_ctl_tb.sv
module trace_gate_ctl_tb;
  localparam int NC = 4;
  localparam logic [11:0] OFS = 12'h088;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          trace_en = 1'b0;
  logic          reg_wr = 1'b0;
  logic [11:0]   reg_addr = OFS;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NC-1:0] cmp_hit = '0;
  logic          ss_active;

  int checks = 0;
  int errors = 0;
  logic exp_act = 1'b0;

  always #2 clk = ~clk;

  trace_gate_ctl #(.NUM_CMP(NC), .ADDR_W(12), .OFFSET(OFS)) u_dut (
    .clk(clk), .rst(rst), .trace_en(trace_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmp_hit(cmp_hit), .ss_active(ss_active)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [11:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0; reg_addr = OFS;
    tick();
  endtask

  initial begin
    repeat (3) tick();
    chk("R8", {31'd0, ss_active}, 32'd0);
    chk("R8", reg_rdata, 32'd0);
    rst = 1'b0;
    tick();

    for (int s = 0; s < 16; s++) begin
      for (int t = 0; t < 16; t++) begin
        trace_en = 1'b0;
        // garbage in reserved and unimplemented bits (R4, R5)
        cfg_write(OFS, {8'hC3, 4'hA, t[3:0], 8'h5A, 4'h6, s[3:0]});
        chk("R5", reg_rdata, {12'h000, t[3:0], 12'h000, s[3:0]});
        chk("R9", {31'd0, ss_active}, 32'd0);
        trace_en = 1'b1;
        exp_act = 1'b0;
        for (int h = 0; h < 16; h++) begin
          logic sh, st;
          cmp_hit = h[3:0];
          st = |(h[3:0] & s[3:0]);
          sh = |(h[3:0] & t[3:0]);
          tick();
          if (sh) exp_act = 1'b0;
          else if (st) exp_act = 1'b1;
          if (sh && st)  chk("R3",  {31'd0, ss_active}, {31'd0, exp_act});
          else if (sh)   chk("R2",  {31'd0, ss_active}, {31'd0, exp_act});
          else if (st)   chk("R1",  {31'd0, ss_active}, {31'd0, exp_act});
          else           chk("R10", {31'd0, ss_active}, {31'd0, exp_act});
        end
        cmp_hit = 4'hF;
        trace_en = 1'b0;
        tick();
        chk("R9", {31'd0, ss_active}, 32'd0);
        cmp_hit = '0;
      end
    end

    // R6: write while enabled is dropped
    trace_en = 1'b0;
    cfg_write(OFS, 32'h0002_0001);
    trace_en = 1'b1;
    cfg_write(OFS, 32'h0001_0004);
    tick();
    chk("R6", reg_rdata, 32'h0002_0001);
    cmp_hit = 4'b0100;
    tick();
    chk("R6", {31'd0, ss_active}, 32'd0);
    cmp_hit = 4'b0001;
    tick();
    chk("R1", {31'd0, ss_active}, 32'd1);
    cmp_hit = 4'b0000;
    tick();
    chk("R10", {31'd0, ss_active}, 32'd1);

    // R7: other offsets
    trace_en = 1'b0;
    cfg_write(12'h08C, 32'h000F_000F);
    reg_addr = 12'h08C;
    tick();
    chk("R7", reg_rdata, 32'd0);
    reg_addr = OFS;
    tick();
    chk("R7", reg_rdata, 32'h0002_0001);

    // R4: all ones
    cfg_write(OFS, 32'hFFFF_FFFF);
    chk("R4", reg_rdata, 32'h000F_000F);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule